// File: doc/BRIEF.md
# Asynchronous Page-Mode Pseudo-Static RAM Controller

This block sits between a simple on-chip request port and a 16-bit pseudo-static RAM that runs in its asynchronous mode. The host hands over one request at a time on a valid/ready port: an array read of one to four words, an array write of one word, or a read or write of the memory's configuration register. The controller then drives the chip select, output enable, write enable, address-valid, configuration-enable, byte-lane and address pins. It drives and samples the data bus through separate out, in and enable signals, and returns each read word on a one-cycle response strobe.

All timing is counted in system clock cycles through parameters: random access time, page access time, write pulse width, the longest time chip select may stay low, and a minimum chip-select-high recovery time. Multi-word reads use page mode. The first word waits the full access time. Each later word changes only the two lowest address bits, wrapping within the four-word page, and waits the shorter page time. When the next page word would push the chip-select-low time past its limit, the controller raises chip select for the recovery time and then reopens the page with a full access time. The memory clock pin is held low.

Top module: `psram_async_ctrl`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it, chip select, output enable and write enable are high, the data-bus enable is low and `req_ready` is high.
- R2: During a read, chip select and output enable are low, write enable stays high, and the address-valid pin is low exactly while chip select is low.
- R3: The first word of a chip-select burst is `dq_in` sampled on the T_AA-th rising edge after chip select falls. It appears on `rsp_data` with `rsp_valid` high for exactly the one cycle after that edge.
- R4: For a read of `req_len`+1 words, word k is read at the request address with bits [1:0] replaced by (addr[1:0]+k) mod 4; the upper address bits never change while chip select is low. Each word after the first in a burst takes T_PA cycles.
- R5: Chip select is never low for more than T_CSM consecutive cycles. If a further page word would exceed that limit, chip select goes high for T_REC cycles and the next word then waits T_AA again.
- R6: A write holds chip select and write enable low with output enable high for T_WP cycles while driving `req_wdata`. Both strobes then rise together, and the data stays driven for one further cycle.
- R7: Byte lanes are active low while chip select is low: `req_be`[0] selects the lower lane, `req_be`[1] the upper lane, and `req_be`=0 selects both. Both lanes are high while chip select is high.
- R8: `req_op` is {config, write}: 00 array read, 01 array write, 10 config read, 11 config write. The configuration-enable pin is high only while chip select is low during a config access. Config accesses select both byte lanes, and a config read returns exactly one word whatever `req_len` is.
- R9: The data-bus enable is never high while output enable is low, and it is low in the cycle before output enable falls.
- R10: `req_ready` is low from the cycle after a request is accepted until chip select has been high for T_REC cycles after the access ends. It is never high while chip select is low.
- R11: The memory clock pin is low at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can accept a request |
| req_op | input | 2 | {config, write} operation code |
| req_addr | input | AW | Word address |
| req_len | input | 2 | Array read length minus one |
| req_be | input | 2 | Byte enables, bit 0 lower lane |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read word strobe |
| rsp_data | output | 16 | Read word |
| mem_clk | output | 1 | Memory clock, held low |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_cre | output | 1 | Configuration register enable |
| mem_lb_n | output | 1 | Lower byte lane select, active low |
| mem_ub_n | output | 1 | Upper byte lane select, active low |
| mem_addr | output | AW | Memory address |
| dq_out | output | 16 | Data driven to the bus |
| dq_oe | output | 1 | Data-bus drive enable |
| dq_in | input | 16 | Data sampled from the bus |

## Verification
The assertions assume that the timing parameters satisfy T_AA, T_PA and T_WP no larger than T_CSM, and T_REC at least one. Under those settings a single read or write word always fits inside one chip-select window. The bench keeps the default parameters, which meet these bounds. It offers requests only when the port is idle and drops `req_valid` right after acceptance. It models the memory as a pure function of the address and configuration-enable pins, so `dq_in` is stable for the whole wait of each word.

// File: rtl/psram_async_ctrl.sv
module psram_async_ctrl #(
  parameter int AW    = 22,
  parameter int T_AA  = 7,
  parameter int T_PA  = 3,
  parameter int T_WP  = 5,
  parameter int T_CSM = 12,
  parameter int T_REC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_len,
  input  logic [1:0]    req_be,
  input  logic [15:0]   req_wdata,
  output logic          rsp_valid,
  output logic [15:0]   rsp_data,
  output logic          mem_clk,
  output logic          mem_cs_n,
  output logic          mem_adv_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_cre,
  output logic          mem_lb_n,
  output logic          mem_ub_n,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   dq_out,
  output logic          dq_oe,
  input  logic [15:0]   dq_in
);

  localparam int TM = (T_CSM > T_REC) ? T_CSM : T_REC;
  localparam int CW = $clog2(TM + 2);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_GAP, S_WR, S_HOLD, S_REC} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cs_run;
  logic [1:0]    idx;
  logic [1:0]    last;
  logic          first;
  logic          is_cfg;
  logic [1:0]    be_q;
  logic [AW-1:0] base;
  logic [15:0]   wd;
  logic [CW-1:0] wait_end;
  logic          cs_act;
  logic          page_fits;

  assign wait_end  = first ? CW'(T_AA - 1) : CW'(T_PA - 1);
  assign page_fits = (int'(cs_run) + 1 + T_PA) <= T_CSM;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      cs_run    <= '0;
      idx       <= '0;
      last      <= '0;
      first     <= 1'b1;
      is_cfg    <= 1'b0;
      be_q      <= 2'b11;
      base      <= '0;
      wd        <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          is_cfg <= req_op[1];
          base   <= req_addr;
          last   <= (req_op != 2'b00) ? 2'd0 : req_len;
          be_q   <= (req_op[1] || req_be == 2'b00) ? 2'b11 : req_be;
          wd     <= req_wdata;
          cnt    <= '0;
          cs_run <= '0;
          idx    <= '0;
          first  <= 1'b1;
          st     <= req_op[0] ? S_WR : S_RD;
        end
        S_RD: begin
          cs_run <= cs_run + 1'b1;
          if (cnt == wait_end) begin
            rsp_valid <= 1'b1;
            rsp_data  <= dq_in;
            cnt       <= '0;
            idx       <= idx + 1'b1;
            first     <= 1'b0;
            if (idx == last)     st <= S_REC;
            else if (!page_fits) begin
              st    <= S_GAP;
              first <= 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_GAP: begin
          if (cnt == CW'(T_REC - 1)) begin
            cnt    <= '0;
            cs_run <= '0;
            st     <= S_RD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WR: begin
          if (cnt == CW'(T_WP - 1)) begin
            cnt <= '0;
            st  <= S_HOLD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_HOLD: st <= S_REC;
        S_REC: begin
          if (cnt == CW'(T_REC - 1)) begin
            cnt <= '0;
            st  <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cs_act    = (st == S_RD) || (st == S_WR);
  assign req_ready = (st == S_IDLE);
  assign mem_clk   = 1'b0;
  assign mem_cs_n  = ~cs_act;
  assign mem_adv_n = ~cs_act;
  assign mem_oe_n  = ~(st == S_RD);
  assign mem_we_n  = ~(st == S_WR);
  assign mem_cre   = cs_act & is_cfg;
  assign mem_lb_n  = ~(cs_act & be_q[0]);
  assign mem_ub_n  = ~(cs_act & be_q[1]);
  assign mem_addr  = {base[AW-1:2], base[1:0] + idx};
  assign dq_out    = wd;
  assign dq_oe     = (st == S_WR) || (st == S_HOLD);

endmodule

// File: rtl/psram_async_ctrl_chk.sv
module psram_async_ctrl_chk #(
  parameter int AW    = 22,
  parameter int T_CSM = 12,
  parameter int T_REC = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          mem_clk,
  input logic          mem_cs_n,
  input logic          mem_adv_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_cre,
  input logic          mem_lb_n,
  input logic          mem_ub_n,
  input logic [AW-1:0] mem_addr,
  input logic [15:0]   dq_out,
  input logic          dq_oe
);

  logic [15:0] lo_run;
  logic [15:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_run <= '0;
      hi_run <= 16'(T_REC);
    end else begin
      lo_run <= mem_cs_n ? 16'd0 : lo_run + 16'd1;
      if (!mem_cs_n)            hi_run <= '0;
      else if (hi_run != '1)    hi_run <= hi_run + 16'd1;
    end
  end

  a_r11_clk_low: assert property (@(posedge clk) disable iff (!rst_n) mem_clk == 1'b0);
  a_r9_no_contention: assert property (@(posedge clk) disable iff (!rst_n) !(dq_oe && !mem_oe_n));
  a_r9_oe_gap: assert property (@(posedge clk) disable iff (!rst_n) $fell(mem_oe_n) |-> !$past(dq_oe));
  a_r2_read_strobes: assert property (@(posedge clk) disable iff (!rst_n) !mem_oe_n |-> (mem_we_n && !mem_cs_n));
  a_r2_adv_follows_cs: assert property (@(posedge clk) disable iff (!rst_n) mem_adv_n == mem_cs_n);
  a_r6_write_strobes: assert property (@(posedge clk) disable iff (!rst_n) !mem_we_n |-> (mem_oe_n && !mem_cs_n && dq_oe));
  a_r6_data_hold: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_we_n) |-> (dq_oe && $stable(dq_out)));
  a_r5_cs_low_limit: assert property (@(posedge clk) disable iff (!rst_n) !mem_cs_n |-> (lo_run < 16'(T_CSM)));
  a_r10_recovery: assert property (@(posedge clk) disable iff (!rst_n) $fell(mem_cs_n) |-> (hi_run >= 16'(T_REC)));
  a_r10_ready_idle: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> mem_cs_n);
  a_r8_cre_inside_cs: assert property (@(posedge clk) disable iff (!rst_n) mem_cre |-> !mem_cs_n);
  a_r7_lane_selected: assert property (@(posedge clk) disable iff (!rst_n) !mem_cs_n |-> !(mem_lb_n && mem_ub_n));
  a_r7_lanes_idle: assert property (@(posedge clk) disable iff (!rst_n) mem_cs_n |-> (mem_lb_n && mem_ub_n));
  a_r4_page_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && !$past(mem_cs_n)) |-> (mem_addr[AW-1:2] == $past(mem_addr[AW-1:2])));
  a_r3_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> !$past(mem_oe_n));

endmodule

bind psram_async_ctrl psram_async_ctrl_chk #(.AW(AW), .T_CSM(T_CSM), .T_REC(T_REC)) u_chk (.*);

// File: tb/tb_psram_async_ctrl.sv
module tb_psram_async_ctrl;
  localparam int AW = 22, T_AA = 7, T_PA = 3, T_WP = 5, T_CSM = 12, T_REC = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_op = '0, req_len = '0, req_be = '0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic rsp_valid;
  logic [15:0] rsp_data;
  logic mem_clk, mem_cs_n, mem_adv_n, mem_oe_n, mem_we_n, mem_cre, mem_lb_n, mem_ub_n, dq_oe;
  logic [AW-1:0] mem_addr;
  logic [15:0] dq_out, dq_in;

  always #5 clk = ~clk;

  psram_async_ctrl #(.AW(AW), .T_AA(T_AA), .T_PA(T_PA), .T_WP(T_WP), .T_CSM(T_CSM), .T_REC(T_REC)) dut (.*);

  function automatic logic [15:0] mval(input logic [AW-1:0] a, input logic c);
    return c ? (16'h3C00 | {8'h00, a[7:0]}) : (a[15:0] ^ 16'hA5C3);
  endfunction
  assign dq_in = mval(mem_addr, mem_cre);

  typedef struct packed {
    logic cs_n, oe_n, we_n, cre, lb_n, ub_n, dqe, ready, rv;
    logic [AW-1:0] addr;
    logic [15:0] dout, rdata;
  } cyc_t;

  cyc_t exp_q[$];
  int checks = 0, errors = 0, cycles = 0;

  function automatic cyc_t idle_c();
    cyc_t c;
    c = '0;
    c.cs_n = 1; c.oe_n = 1; c.we_n = 1; c.lb_n = 1; c.ub_n = 1; c.ready = 1;
    return c;
  endfunction

  function automatic cyc_t busy_c();
    cyc_t c;
    c = idle_c();
    c.ready = 0;
    return c;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic step();
    cyc_t e;
    @(negedge clk);
    cycles++;
    e = (exp_q.size() > 0) ? exp_q.pop_front() : idle_c();
    chk("R5", "cs_n", 32'(mem_cs_n), 32'(e.cs_n));
    chk("R2", "adv_n", 32'(mem_adv_n), 32'(e.cs_n));
    chk("R2", "oe_n", 32'(mem_oe_n), 32'(e.oe_n));
    chk("R6", "we_n", 32'(mem_we_n), 32'(e.we_n));
    chk("R8", "cre", 32'(mem_cre), 32'(e.cre));
    chk("R7", "lb_n", 32'(mem_lb_n), 32'(e.lb_n));
    chk("R7", "ub_n", 32'(mem_ub_n), 32'(e.ub_n));
    chk("R9", "dq_oe", 32'(dq_oe), 32'(e.dqe));
    chk("R10", "ready", 32'(req_ready), 32'(e.ready));
    chk("R3", "rsp_valid", 32'(rsp_valid), 32'(e.rv));
    chk("R11", "mem_clk", 32'(mem_clk), 32'd0);
    if (!e.cs_n) chk("R4", "addr", 32'(mem_addr), 32'(e.addr));
    if (e.dqe)   chk("R6", "dq_out", 32'(dq_out), 32'(e.dout));
    if (e.rv)    chk("R3", "rsp_data", 32'(rsp_data), 32'(e.rdata));
  endtask

  task automatic push_read(input logic [AW-1:0] a0, input logic [1:0] len, input logic [1:0] be, input logic cfg);
    int n, run, wl;
    logic first, pend;
    logic [15:0] pdata;
    logic [1:0] bee;
    cyc_t c;
    n = cfg ? 1 : int'(len) + 1;
    bee = (cfg || be == 2'b00) ? 2'b11 : be;
    run = 0; first = 1; pend = 0; pdata = '0;
    for (int w = 0; w < n; w++) begin
      logic [AW-1:0] a;
      a = {a0[AW-1:2], 2'(a0[1:0] + 2'(w))};
      wl = first ? T_AA : T_PA;
      for (int j = 0; j < wl; j++) begin
        c = busy_c();
        c.cs_n = 0; c.oe_n = 0; c.cre = cfg; c.lb_n = ~bee[0]; c.ub_n = ~bee[1];
        c.addr = a; c.rv = pend; c.rdata = pdata;
        exp_q.push_back(c);
        pend = 0;
      end
      pend = 1; pdata = mval(a, cfg); run += wl; first = 0;
      if (w < n - 1 && run + T_PA > T_CSM) begin
        for (int j = 0; j < T_REC; j++) begin
          c = busy_c(); c.rv = pend; c.rdata = pdata;
          exp_q.push_back(c);
          pend = 0;
        end
        run = 0; first = 1;
      end
    end
    for (int j = 0; j < T_REC; j++) begin
      c = busy_c(); c.rv = pend; c.rdata = pdata;
      exp_q.push_back(c);
      pend = 0;
    end
  endtask

  task automatic push_write(input logic [AW-1:0] a, input logic [1:0] be, input logic cfg, input logic [15:0] d);
    logic [1:0] bee;
    cyc_t c;
    bee = (cfg || be == 2'b00) ? 2'b11 : be;
    for (int j = 0; j < T_WP; j++) begin
      c = busy_c();
      c.cs_n = 0; c.we_n = 0; c.cre = cfg; c.lb_n = ~bee[0]; c.ub_n = ~bee[1];
      c.addr = a; c.dqe = 1; c.dout = d;
      exp_q.push_back(c);
    end
    c = busy_c(); c.dqe = 1; c.dout = d;
    exp_q.push_back(c);
    for (int j = 0; j < T_REC; j++) exp_q.push_back(busy_c());
  endtask

  task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, input logic [1:0] len,
                       input logic [1:0] be, input logic [15:0] d);
    step();
    req_op = op; req_addr = a; req_len = len; req_be = be; req_wdata = d; req_valid = 1'b1;
    if (op[0]) push_write(a, be, op[1], d);
    else       push_read(a, len, be, op[1]);
    step();
    req_valid = 1'b0;
    while (exp_q.size() > 0) step();
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1", "reset cs_n", 32'(mem_cs_n), 32'd1);
      chk("R1", "reset oe_n", 32'(mem_oe_n), 32'd1);
      chk("R1", "reset we_n", 32'(mem_we_n), 32'd1);
      chk("R1", "reset dq_oe", 32'(dq_oe), 32'd0);
      chk("R1", "reset ready", 32'(req_ready), 32'd1);
    end
    rst_n = 1'b1;
    step();
    issue(2'b00, 22'h000123, 2'd0, 2'b11, 16'h0);   // R3 single word
    issue(2'b00, 22'h012345, 2'd3, 2'b11, 16'h0);   // R4 wrap, R5 split
    issue(2'b00, 22'h2ABCD2, 2'd2, 2'b01, 16'h0);   // R4 three words, R7 lower lane
    issue(2'b01, 22'h000777, 2'd0, 2'b10, 16'hBEEF); // R6 write, R7 upper lane
    issue(2'b00, 22'h000777, 2'd1, 2'b00, 16'h0);   // R9 read after write, R7 both
    issue(2'b01, 22'h3FFFFF, 2'd0, 2'b00, 16'h1234); // R7 no lanes -> both
    issue(2'b10, 22'h000002, 2'd3, 2'b01, 16'h0);   // R8 config read single word
    issue(2'b11, 22'h000001, 2'd2, 2'b10, 16'h8A1F); // R8 config write
    issue(2'b00, 22'h155550, 2'd3, 2'b10, 16'h0);   // R5 split from aligned page
    for (int i = 0; i < 4; i++) step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL R10 watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule